// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block works out the setup values for a polyphase image scaler that uses 16 filter phases (a 4-bit phase index) and a 12-bit sub-phase fraction. A request gives the source rectangle of the scaled plane in unsigned 16.16 fixed point, the integer size of the destination rectangle, a flag that says the plane is turned by a quarter turn, and a mask of the planes that ask for scaling. After a `start` pulse the block latches all operands and returns, per axis, the upscale factor, the initial phase and the phase step. It also returns an enhancer enable for large upscales.

The mask is checked first. An empty mask turns scaling off. A mask with more than one bit set is refused, because the scaler serves a single plane. A zero dimension sets an error flag and no division runs. Otherwise one restoring divider handles all six quotients in turn. `done` pulses when the outcome is ready, and the results hold until the next accepted `start`.

Top module: `sc_phase_calc`

## Requirements
- R1: When the latched mask has two or more bits set (mask AND (mask minus 1) is non-zero), the run ends with `reject`=1, `scale_en`=0, `zero_err`=0 and all six results at 0. This check has priority over the zero-dimension check.
- R2: An all-zero mask ends the run with `scale_en`=0, `reject`=0, `zero_err`=0, `enh_en`=0 and all results at 0.
- R3: With exactly one mask bit set, a zero value in any of `src_w`, `src_h`, `dst_w` or `dst_h` ends the run with `zero_err`=1, `scale_en`=0 and all results at 0.
- R4: `h_up` = (dst_w × 2^32) / src_w and `v_up` = (dst_h × 2^32) / src_h, both truncated to 32 bits (unsigned 16.16).
- R5: With `rotated`=0 the input width is src_w[31:16] and the input height is src_h[31:16]. With `rotated`=1 the input width is src_h[31:16] and the input height is src_w[31:16].
- R6: `h_init` = ((in_w × 16) / dst_w + 1) / 2 and `v_init` = ((in_h × 16) / dst_h + 1) / 2, using integer division.
- R7: `h_delta` = (in_w × 65536) / dst_w and `v_delta` = (in_h × 65536) / dst_h.
- R8: On a successful run, `enh_en` is 1 exactly when h_up[31:16] ≥ 2 or v_up[31:16] ≥ 2, and `scale_en` is 1.
- R9: `done` is a one-cycle pulse with `busy`=0. After it, the results and flags hold until the next accepted `start`. A `start` that arrives while `busy`=1 is ignored, and the run in progress completes on its own latched operands.
- R10: Reset, including a reset during a run, returns every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only while idle |
| scale_mask | input | 4 | One bit per plane asking for scaling |
| src_w | input | 32 | Source width, unsigned 16.16 |
| src_h | input | 32 | Source height, unsigned 16.16 |
| dst_w | input | 16 | Destination width in pixels |
| dst_h | input | 16 | Destination height in pixels |
| rotated | input | 1 | Swap the axes of the source |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| scale_en | output | 1 | Scaling parameters valid |
| reject | output | 1 | More than one plane asked for scaling |
| zero_err | output | 1 | A dimension was zero |
| enh_en | output | 1 | Upscale of 2x or more on some axis |
| h_up | output | 32 | Horizontal upscale factor, 16.16 |
| v_up | output | 32 | Vertical upscale factor, 16.16 |
| h_init | output | 32 | Horizontal initial phase |
| h_delta | output | 32 | Horizontal phase step |
| v_init | output | 32 | Vertical initial phase |
| v_delta | output | 32 | Vertical phase step |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of a divider sequence with different operands on the inputs. The stimulus starts one run, waits some cycles, then drives a new operand set and pulses `start` again. The results must still match the first operand set. The corners of the divider are also driven. A source below one pixel makes the input dimension zero. A 1/65536 source against the largest destination makes the 48-bit quotient truncate to zero. A 1.0 source against the largest destination gives the largest factor that fits.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    OP_HUP    = 3'd0,
    OP_VUP    = 3'd1,
    OP_HINIT  = 3'd2,
    OP_HDELTA = 3'd3,
    OP_VINIT  = 3'd4,
    OP_VDELTA = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3
  } st_e;
endpackage

// File: rtl/sc_restoring_div.sv
module sc_restoring_div #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             valid,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DEN_W + 1;

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] shf_q, num_chk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, valid_q;
  logic [DEN_W:0]   trial, diff;
  logic             take;

  always_comb begin
    trial = {rem_q, shf_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    take  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      valid_q   <= 1'b0;
      rem_q     <= '0;
      den_q     <= '0;
      shf_q     <= '0;
      num_chk_q <= '0;
      cnt_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start && !run_q) begin
        run_q     <= 1'b1;
        rem_q     <= '0;
        shf_q     <= num;
        den_q     <= den;
        num_chk_q <= num;
        cnt_q     <= '0;
      end else if (run_q) begin
        rem_q <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        shf_q <= {shf_q[NUM_W-2:0], take};
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(NUM_W - 1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid = valid_q;
  assign quo   = shf_q;

  // R3: the controller never starts a division by zero
  assert_no_div_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !run_q) |-> (den != '0));

  // R4 R6 R7: quotient satisfies q*d <= n < (q+1)*d
  assert_div_exact_R4: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((PW'(shf_q) * PW'(den_q) <= PW'(num_chk_q)) &&
                 (PW'(shf_q) * PW'(den_q) + PW'(den_q) > PW'(num_chk_q))));
endmodule

// File: rtl/sc_phase_ctrl.sv
module sc_phase_ctrl
  import sc_pkg::*;
#(
  parameter int SRC_W   = 32,
  parameter int FRAC_W  = 16,
  parameter int DST_W   = 16,
  parameter int MASK_W  = 4,
  parameter int PH_BITS = 4,
  parameter int PH_FRAC = 12,
  parameter int OUT_W   = 32,
  parameter int NUM_W   = 48,
  parameter int DEN_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MASK_W-1:0] scale_mask,
  input  logic [SRC_W-1:0]  src_w,
  input  logic [SRC_W-1:0]  src_h,
  input  logic [DST_W-1:0]  dst_w,
  input  logic [DST_W-1:0]  dst_h,
  input  logic              rotated,
  output logic              div_start,
  output logic [NUM_W-1:0]  div_num,
  output logic [DEN_W-1:0]  div_den,
  input  logic              div_valid,
  input  logic [NUM_W-1:0]  div_quo,
  output logic              busy,
  output logic              done,
  output logic              scale_en,
  output logic              reject,
  output logic              zero_err,
  output logic              enh_en,
  output logic [OUT_W-1:0]  h_up,
  output logic [OUT_W-1:0]  v_up,
  output logic [OUT_W-1:0]  h_init,
  output logic [OUT_W-1:0]  h_delta,
  output logic [OUT_W-1:0]  v_init,
  output logic [OUT_W-1:0]  v_delta
);
  localparam int INT_W    = SRC_W - FRAC_W;
  localparam int UP_SH    = 2 * FRAC_W;
  localparam int DELTA_SH = PH_BITS + PH_FRAC;

  st_e              st_q;
  op_e              op_q;
  logic [MASK_W-1:0] mask_q;
  logic [SRC_W-1:0] sw_q, sh_q;
  logic [DST_W-1:0] dw_q, dh_q;
  logic             rot_q;
  logic [INT_W-1:0] in_w, in_h;
  logic             multi, any_zero;
  logic [NUM_W-1:0] rounded;

  logic             busy_q, done_q, scale_q, reject_q, zerr_q, enh_q;
  logic [OUT_W-1:0] hup_q, vup_q, hini_q, hdel_q, vini_q, vdel_q;

  always_comb begin
    in_w     = rot_q ? sh_q[SRC_W-1:FRAC_W] : sw_q[SRC_W-1:FRAC_W];
    in_h     = rot_q ? sw_q[SRC_W-1:FRAC_W] : sh_q[SRC_W-1:FRAC_W];
    multi    = (mask_q & (mask_q - MASK_W'(1))) != '0;
    any_zero = (sw_q == '0) || (sh_q == '0) || (dw_q == '0) || (dh_q == '0);
    rounded  = (div_quo + NUM_W'(1)) >> 1;
    div_start = (st_q == ST_ISSUE);
    unique case (op_q)
      OP_HUP:    begin div_num = NUM_W'(dw_q) << UP_SH;    div_den = DEN_W'(sw_q); end
      OP_VUP:    begin div_num = NUM_W'(dh_q) << UP_SH;    div_den = DEN_W'(sh_q); end
      OP_HINIT:  begin div_num = NUM_W'(in_w) << PH_BITS;  div_den = DEN_W'(dw_q); end
      OP_HDELTA: begin div_num = NUM_W'(in_w) << DELTA_SH; div_den = DEN_W'(dw_q); end
      OP_VINIT:  begin div_num = NUM_W'(in_h) << PH_BITS;  div_den = DEN_W'(dh_q); end
      default:   begin div_num = NUM_W'(in_h) << DELTA_SH; div_den = DEN_W'(dh_q); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;  op_q <= OP_HUP;
      mask_q <= '0; sw_q <= '0; sh_q <= '0; dw_q <= '0; dh_q <= '0; rot_q <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0; scale_q <= 1'b0;
      reject_q <= 1'b0; zerr_q <= 1'b0; enh_q <= 1'b0;
      hup_q <= '0; vup_q <= '0; hini_q <= '0; hdel_q <= '0; vini_q <= '0; vdel_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          mask_q <= scale_mask; sw_q <= src_w; sh_q <= src_h;
          dw_q <= dst_w; dh_q <= dst_h; rot_q <= rotated;
          busy_q <= 1'b1; scale_q <= 1'b0; reject_q <= 1'b0;
          zerr_q <= 1'b0; enh_q <= 1'b0;
          hup_q <= '0; vup_q <= '0; hini_q <= '0; hdel_q <= '0; vini_q <= '0; vdel_q <= '0;
          st_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (mask_q == '0 || multi || any_zero) begin
            reject_q <= multi;
            zerr_q   <= (mask_q != '0) && !multi;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            op_q <= OP_HUP;
            st_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (div_valid) begin
          unique case (op_q)
            OP_HUP:    hup_q  <= OUT_W'(div_quo);
            OP_VUP:    vup_q  <= OUT_W'(div_quo);
            OP_HINIT:  hini_q <= OUT_W'(rounded);
            OP_HDELTA: hdel_q <= OUT_W'(div_quo);
            OP_VINIT:  vini_q <= OUT_W'(rounded);
            default:   vdel_q <= OUT_W'(div_quo);
          endcase
          if (op_q == OP_VDELTA) begin
            scale_q <= 1'b1;
            enh_q   <= (hup_q[OUT_W-1:FRAC_W] >= (OUT_W-FRAC_W)'(2)) ||
                       (vup_q[OUT_W-1:FRAC_W] >= (OUT_W-FRAC_W)'(2));
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            op_q <= op_e'(op_q + 3'd1);
            st_q <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;     assign done = done_q;
  assign scale_en = scale_q; assign reject = reject_q;
  assign zero_err = zerr_q;  assign enh_en = enh_q;
  assign h_up = hup_q;  assign v_up = vup_q;
  assign h_init = hini_q; assign h_delta = hdel_q;
  assign v_init = vini_q; assign v_delta = vdel_q;

  // R1: a refused request carries no other outcome
  assert_reject_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    (done_q && reject_q) |-> (!scale_q && !zerr_q && hdel_q == '0 && vup_q == '0));

  // R2: empty mask finishes with every flag low
  assert_empty_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (done_q && mask_q == '0) |-> (!scale_q && !reject_q && !zerr_q && !enh_q));

  // R3: zero dimension never yields parameters
  assert_zero_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (done_q && zerr_q) |-> (!scale_q && hup_q == '0));

  // R8: the enhancer only comes with a successful run
  assert_enh_needs_scale_R8: assert property (@(posedge clk) disable iff (rst)
    enh_q |-> scale_q);

  // R9: done is one cycle wide and never overlaps busy
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R9: results hold while idle without a new request
  assert_hold_results_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start) |=> ($stable(hdel_q) && $stable(vini_q) && $stable(hup_q) && $stable(scale_q)));
endmodule

// File: rtl/sc_phase_calc.sv
module sc_phase_calc #(
  parameter int SRC_W   = 32,
  parameter int FRAC_W  = 16,
  parameter int DST_W   = 16,
  parameter int MASK_W  = 4,
  parameter int PH_BITS = 4,
  parameter int PH_FRAC = 12,
  parameter int OUT_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MASK_W-1:0] scale_mask,
  input  logic [SRC_W-1:0]  src_w,
  input  logic [SRC_W-1:0]  src_h,
  input  logic [DST_W-1:0]  dst_w,
  input  logic [DST_W-1:0]  dst_h,
  input  logic              rotated,
  output logic              busy,
  output logic              done,
  output logic              scale_en,
  output logic              reject,
  output logic              zero_err,
  output logic              enh_en,
  output logic [OUT_W-1:0]  h_up,
  output logic [OUT_W-1:0]  v_up,
  output logic [OUT_W-1:0]  h_init,
  output logic [OUT_W-1:0]  h_delta,
  output logic [OUT_W-1:0]  v_init,
  output logic [OUT_W-1:0]  v_delta
);
  localparam int NUM_W = DST_W + 2 * FRAC_W;
  localparam int DEN_W = (SRC_W > DST_W) ? SRC_W : DST_W;

  logic             div_start, div_valid;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [DEN_W-1:0] div_den;

  sc_phase_ctrl #(
    .SRC_W(SRC_W), .FRAC_W(FRAC_W), .DST_W(DST_W), .MASK_W(MASK_W),
    .PH_BITS(PH_BITS), .PH_FRAC(PH_FRAC), .OUT_W(OUT_W),
    .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .scale_mask(scale_mask),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h), .rotated(rotated),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .div_valid(div_valid), .div_quo(div_quo),
    .busy(busy), .done(done), .scale_en(scale_en), .reject(reject),
    .zero_err(zero_err), .enh_en(enh_en),
    .h_up(h_up), .v_up(v_up), .h_init(h_init), .h_delta(h_delta),
    .v_init(v_init), .v_delta(v_delta)
  );

  sc_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .valid(div_valid), .quo(div_quo)
  );
endmodule

// File: tb/sim_sc_phase_calc.sv
module sim_sc_phase_calc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  scale_mask = '0;
  logic [31:0] src_w = '0, src_h = '0;
  logic [15:0] dst_w = '0, dst_h = '0;
  logic        rotated = 1'b0;
  logic        busy, done, scale_en, reject, zero_err, enh_en;
  logic [31:0] h_up, v_up, h_init, h_delta, v_init, v_delta;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sc_phase_calc u0 (
    .clk(clk), .rst(rst), .start(start), .scale_mask(scale_mask),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h), .rotated(rotated),
    .busy(busy), .done(done), .scale_en(scale_en), .reject(reject),
    .zero_err(zero_err), .enh_en(enh_en), .h_up(h_up), .v_up(v_up),
    .h_init(h_init), .h_delta(h_delta), .v_init(v_init), .v_delta(v_delta)
  );

  // {src_w, src_h, dst_w, dst_h, rotated, mask}
  localparam int NV = 8;
  localparam logic [100:0] VEC [NV] = '{
    {32'h0780_0000, 32'h0438_0000, 16'd3840,  16'd2160,  1'b0, 4'b0010},
    {32'h0500_0000, 32'h02D0_0000, 16'd1920,  16'd1080,  1'b0, 4'b0001},
    {32'h0438_0000, 32'h0780_0000, 16'd1920,  16'd1080,  1'b1, 4'b1000},
    {32'h0F00_0000, 32'h0870_0000, 16'd640,   16'd480,   1'b0, 4'b0100},
    {32'h0064_8000, 32'h0032_4000, 16'd301,   16'd75,    1'b1, 4'b0001},
    {32'h0001_0000, 32'h0001_0000, 16'd65535, 16'd65535, 1'b0, 4'b0010},
    {32'h0000_8000, 32'h0003_0000, 16'd1,     16'd7,     1'b0, 4'b1000},
    {32'h0000_0001, 32'h000A_0000, 16'd65535, 16'd10,    1'b1, 4'b0100}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] sw, sh, input logic [15:0] dw, dh,
      input logic r, output logic [31:0] hu, vu, hi, hd, vi, vd, output logic e);
    logic [63:0] iw, ih, t;
    iw = r ? 64'(sh[31:16]) : 64'(sw[31:16]);
    ih = r ? 64'(sw[31:16]) : 64'(sh[31:16]);
    t  = (64'(dw) << 32) / 64'(sw);  hu = t[31:0];
    t  = (64'(dh) << 32) / 64'(sh);  vu = t[31:0];
    t  = ((iw << 4) / 64'(dw) + 1) / 2; hi = t[31:0];
    t  = (iw << 16) / 64'(dw);          hd = t[31:0];
    t  = ((ih << 4) / 64'(dh) + 1) / 2; vi = t[31:0];
    t  = (ih << 16) / 64'(dh);          vd = t[31:0];
    e  = (hu[31:16] >= 16'd2) || (vu[31:16] >= 16'd2);
  endfunction

  task automatic issue(input logic [31:0] sw, sh, input logic [15:0] dw, dh,
                       input logic r, input logic [3:0] m);
    @(negedge clk);
    src_w = sw; src_h = sh; dst_w = dw; dst_h = dh; rotated = r; scale_mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    checks++;
    if (!done) begin
      failures++;
      $display("FAIL %s done never rose actual=0 expected=1", req);
    end
  endtask

  task automatic chk_results(input string req, input logic [31:0] hu, vu, hi, hd, vi, vd);
    chk(req, "h_up", h_up, hu);     chk(req, "v_up", v_up, vu);
    chk(req, "h_init", h_init, hi); chk(req, "h_delta", h_delta, hd);
    chk(req, "v_init", v_init, vi); chk(req, "v_delta", v_delta, vd);
  endtask

  initial begin
    #(20 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] hu, vu, hi, hd, vi, vd;
    logic e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10", "busy", 32'(busy), 0); chk("R10", "done", 32'(done), 0);
    chk("R10", "scale_en", 32'(scale_en), 0);
    chk_results("R10", 0, 0, 0, 0, 0, 0);

    // Table of vectors: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [100:0] v = VEC[i];
      model(v[100:69], v[68:37], v[36:21], v[20:5], v[4], hu, vu, hi, hd, vi, vd, e);
      issue(v[100:69], v[68:37], v[36:21], v[20:5], v[4], v[3:0]);
      wait_done("R9");
      chk("R4", "h_up/v_up", h_up ^ v_up, hu ^ vu);
      chk_results(v[4] ? "R5" : "R6", hu, vu, hi, hd, vi, vd);
      chk("R7", "h_delta", h_delta, hd);
      chk("R8", "enh_en", 32'(enh_en), 32'(e));
      chk("R8", "scale_en", 32'(scale_en), 1);
      chk("R9", "busy at done", 32'(busy), 0);
      @(negedge clk);
      chk("R9", "done pulse width", 32'(done), 0);
    end

    // R2: empty mask
    issue(32'h0100_0000, 32'h0100_0000, 16'd512, 16'd512, 1'b0, 4'b0000);
    wait_done("R2");
    chk("R2", "scale_en", 32'(scale_en), 0); chk("R2", "reject", 32'(reject), 0);
    chk("R2", "zero_err", 32'(zero_err), 0); chk("R2", "enh_en", 32'(enh_en), 0);
    chk_results("R2", 0, 0, 0, 0, 0, 0);

    // R1: two planes request scaling
    issue(32'h0100_0000, 32'h0100_0000, 16'd512, 16'd512, 1'b0, 4'b0110);
    wait_done("R1");
    chk("R1", "reject", 32'(reject), 1); chk("R1", "scale_en", 32'(scale_en), 0);
    chk_results("R1", 0, 0, 0, 0, 0, 0);

    // R1: refusal has priority over a zero dimension
    issue(32'h0100_0000, 32'h0, 16'd0, 16'd512, 1'b0, 4'b1111);
    wait_done("R1");
    chk("R1", "reject", 32'(reject), 1); chk("R1", "zero_err", 32'(zero_err), 0);

    // R3: zero destination width, then zero source height
    issue(32'h0100_0000, 32'h0100_0000, 16'd0, 16'd512, 1'b0, 4'b1000);
    wait_done("R3");
    chk("R3", "zero_err dst", 32'(zero_err), 1); chk("R3", "scale_en", 32'(scale_en), 0);
    chk_results("R3", 0, 0, 0, 0, 0, 0);
    issue(32'h0100_0000, 32'h0, 16'd512, 16'd512, 1'b0, 4'b0001);
    wait_done("R3");
    chk("R3", "zero_err src", 32'(zero_err), 1); chk("R3", "reject", 32'(reject), 0);

    // R9: start while busy is ignored
    model(32'h0500_0000, 32'h02D0_0000, 16'd1920, 16'd1080, 1'b0, hu, vu, hi, hd, vi, vd, e);
    issue(32'h0500_0000, 32'h02D0_0000, 16'd1920, 16'd1080, 1'b0, 4'b0001);
    repeat (20) @(negedge clk);
    chk("R9", "busy mid run", 32'(busy), 1);
    issue(32'h0010_0000, 32'h0020_0000, 16'd7, 16'd9, 1'b1, 4'b0011);
    wait_done("R9");
    chk("R9", "second start ignored", 32'(reject), 0);
    chk_results("R9", hu, vu, hi, hd, vi, vd);

    // R9: results hold with inputs changing and no start
    @(negedge clk);
    src_w = 32'h0; dst_w = 16'd3; scale_mask = 4'b1111;
    repeat (10) @(negedge clk);
    chk("R9", "done stays low", 32'(done), 0);
    chk("R9", "scale_en hold", 32'(scale_en), 1);
    chk_results("R9", hu, vu, hi, hd, vi, vd);

    // R10: reset in the middle of a run
    issue(32'h0780_0000, 32'h0438_0000, 16'd3840, 16'd2160, 1'b0, 4'b0010);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy after reset", 32'(busy), 0);
    chk("R10", "scale_en after reset", 32'(scale_en), 0);
    chk_results("R10", 0, 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule